// File: doc/BRIEF.md
# Bit-Serial Nonlinear/Linear Keystream Generator (80-bit)

This block produces a cipher keystream one bit at a time. It holds two 80-bit shift registers that both shift toward bit 0 on every enabled clock: a linear register and a nonlinear register. Only bit 79 of each register receives new computed feedback. The output bit is built from a nonlinear filter over selected bits of both registers, XORed with a fixed set of nonlinear-register bits.

A load strobe seeds the registers from an 80-bit key and a 64-bit IV. The block then runs 160 enabled clocks of initialization. During those clocks it folds its own output bit back into both feedback inputs and marks no output valid. After that, every enabled clock delivers one keystream bit, with a valid flag, on the next cycle. The clock enable lets the host pause the generator at any point without losing state.

Top module: `keystream_gen80`

## Requirements
- R1: A low `rst_n` at a clock edge (synchronous, active low) clears both registers and the initialization state. On the next cycle `ks_valid` and `ks_bit` are 0. Until a load arrives, no keystream bit is ever marked valid.
- R2: A clock edge with `load` high takes effect whether `en` is high or low. It places `key[79:0]` in the nonlinear register, `iv[63:0]` in linear-register bits 63..0 and ones in linear-register bits 79..64. It then starts a fresh initialization, even when a previous initialization or keystream run was in progress.
- R3: After a load, the first 160 clocks with `en` high are initialization clocks. On each of them the output bit z is XORed into both bit-79 feedback inputs, and `ks_valid` stays 0. The 161st enabled clock after the load produces the first valid bit.
- R4: On every enabled shift, each bit i in 0..78 of the linear register takes bit i+1. Bit 79 takes s62^s51^s38^s23^s13^s0, XORed with z during initialization.
- R5: On every enabled shift, each bit i in 0..78 of the nonlinear register takes bit i+1. Bit 79 takes s0^b0^b62^b60^b52^b45^b37^b33^b28^b21^b14^b9^b63b60^b37b33^b15b9^b60b52b45^b33b28b21^b63b45b28b9^b60b52b37b33^b63b60b21b15^b63b60b52b45b37^b33b28b21b15b9^b52b45b37b33b28b21, XORed with z during initialization. In these terms s is a linear-register bit and b is a nonlinear-register bit.
- R6: The output bit is z = H ^ b1^b2^b4^b10^b31^b43^b56, where H = s25^b63^s3s4^s46s4^s4b63^s3s25s46^s3s46s4^s3s46b63^s25s46b63^s46s4b63. z is computed from the state before the shift. On an enabled keystream clock, z appears on `ks_bit` with `ks_valid` high in the following cycle.
- R7: A clock edge with `en` low and no load leaves both registers and the initialization count unchanged and gives `ks_valid` 0 on the next cycle. The keystream continues without a gap once `en` returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock enable for initialization and keystream steps |
| load | input | 1 | Seed registers from key and IV and restart initialization |
| key | input | 80 | Key, loaded into the nonlinear register |
| iv | input | 64 | IV, loaded into the low 64 bits of the linear register |
| ks_bit | output | 1 | Keystream bit, meaningful when ks_valid is high |
| ks_valid | output | 1 | High for one cycle per delivered keystream bit |

## Verification
The bench compares the design against a behavioural model on every clock. A single wrong bit in either register reaches z within a few clocks, because the filter and output taps sit at low indices and every bit passes through them as the registers shift. A fault in the feedback, such as a wrong tap, a missing product term or a missing z fold during initialization, corrupts the state entered at bit 79. That corrupted state then reaches the output taps within about 80 clocks. Counting and enable faults show up immediately as a `ks_valid` timing mismatch, for example a first bit delivered one cycle early or late, or a valid flag during a pause.

// File: rtl/keystream_gen80.sv
module keystream_gen80 #(
  parameter int INIT_CLOCKS = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        load,
  input  logic [79:0] key,
  input  logic [63:0] iv,
  output logic        ks_bit,
  output logic        ks_valid
);
  localparam int CW = $clog2(INIT_CLOCKS + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_INIT, PH_RUN} phase_t;

  logic [79:0] s, b;
  logic [CW-1:0] cnt;
  phase_t phase;
  logic lin_fb, nl_fb, filt, z, fold;

  assign lin_fb = s[62] ^ s[51] ^ s[38] ^ s[23] ^ s[13] ^ s[0];

  assign nl_fb = s[0] ^ b[0] ^ b[62] ^ b[60] ^ b[52] ^ b[45] ^ b[37] ^ b[33]
               ^ b[28] ^ b[21] ^ b[14] ^ b[9]
               ^ (b[63] & b[60]) ^ (b[37] & b[33]) ^ (b[15] & b[9])
               ^ (b[60] & b[52] & b[45]) ^ (b[33] & b[28] & b[21])
               ^ (b[63] & b[45] & b[28] & b[9])
               ^ (b[60] & b[52] & b[37] & b[33])
               ^ (b[63] & b[60] & b[21] & b[15])
               ^ (b[63] & b[60] & b[52] & b[45] & b[37])
               ^ (b[33] & b[28] & b[21] & b[15] & b[9])
               ^ (b[52] & b[45] & b[37] & b[33] & b[28] & b[21]);

  assign filt = s[25] ^ b[63] ^ (s[3] & s[4]) ^ (s[46] & s[4]) ^ (s[4] & b[63])
              ^ (s[3] & s[25] & s[46]) ^ (s[3] & s[46] & s[4])
              ^ (s[3] & s[46] & b[63]) ^ (s[25] & s[46] & b[63])
              ^ (s[46] & s[4] & b[63]);

  assign z = filt ^ b[1] ^ b[2] ^ b[4] ^ b[10] ^ b[31] ^ b[43] ^ b[56];

  assign fold = (phase == PH_INIT) & z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s        <= '0;
      b        <= '0;
      cnt      <= '0;
      phase    <= PH_IDLE;
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else if (load) begin
      b        <= key;
      s        <= {16'hFFFF, iv};
      cnt      <= CW'(INIT_CLOCKS);
      phase    <= PH_INIT;
      ks_valid <= 1'b0;
    end else begin
      ks_valid <= 1'b0;
      if (en && phase != PH_IDLE) begin
        s <= {lin_fb ^ fold, s[79:1]};
        b <= {nl_fb ^ fold, b[79:1]};
        if (phase == PH_INIT) begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) phase <= PH_RUN;
        end else begin
          ks_bit   <= z;
          ks_valid <= 1'b1;
        end
      end
    end
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (!ks_valid && !ks_bit));

  // R2
  load_seeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (b == $past(key)) && (s[63:0] == $past(iv)) && (s[79:64] == 16'hFFFF)
             && (phase == PH_INIT) && (cnt == CW'(INIT_CLOCKS)));

  // R3
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN) |=> !ks_valid);

  // R4
  lin_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && phase != PH_IDLE) |=> (s[78:0] == $past(s[79:1])));

  // R5
  nl_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && phase != PH_IDLE) |=> (b[78:0] == $past(b[79:1])));

  // R6
  valid_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_valid |-> ($past(en) && !$past(load)));

  // R7
  pause_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> ($stable(s) && $stable(b) && $stable(cnt) && !ks_valid));
endmodule

// File: tb/test_keystream_gen80.sv
module test_keystream_gen80;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic load = 1'b0;
  logic [79:0] key = '0;
  logic [63:0] iv = '0;
  logic ks_bit, ks_valid;

  int tests = 0;
  int fails = 0;

  keystream_gen80 i_keystream_gen80 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .key(key), .iv(iv), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  always #4 clk = ~clk;

  bit ms[80];
  bit mb[80];
  int mphase = 0;
  int mcnt = 0;
  bit mvalid = 1'b0;
  bit mbit = 1'b0;
  bit compare_on = 1'b0;
  int first_gap = 0;

  function automatic bit model_z();
    bit h;
    h = ms[25] ^ mb[63] ^ (ms[3] & ms[4]) ^ (ms[46] & ms[4]) ^ (ms[4] & mb[63])
      ^ (ms[3] & ms[25] & ms[46]) ^ (ms[3] & ms[46] & ms[4])
      ^ (ms[3] & ms[46] & mb[63]) ^ (ms[25] & ms[46] & mb[63])
      ^ (ms[46] & ms[4] & mb[63]);
    return h ^ mb[1] ^ mb[2] ^ mb[4] ^ mb[10] ^ mb[31] ^ mb[43] ^ mb[56];
  endfunction

  function automatic bit model_lin();
    return ms[62] ^ ms[51] ^ ms[38] ^ ms[23] ^ ms[13] ^ ms[0];
  endfunction

  function automatic bit model_nl();
    bit t;
    t = ms[0] ^ mb[0] ^ mb[62] ^ mb[60] ^ mb[52] ^ mb[45] ^ mb[37] ^ mb[33]
      ^ mb[28] ^ mb[21] ^ mb[14] ^ mb[9];
    t ^= mb[63] & mb[60];
    t ^= mb[37] & mb[33];
    t ^= mb[15] & mb[9];
    t ^= mb[60] & mb[52] & mb[45];
    t ^= mb[33] & mb[28] & mb[21];
    t ^= mb[63] & mb[45] & mb[28] & mb[9];
    t ^= mb[60] & mb[52] & mb[37] & mb[33];
    t ^= mb[63] & mb[60] & mb[21] & mb[15];
    t ^= mb[63] & mb[60] & mb[52] & mb[45] & mb[37];
    t ^= mb[33] & mb[28] & mb[21] & mb[15] & mb[9];
    t ^= mb[52] & mb[45] & mb[37] & mb[33] & mb[28] & mb[21];
    return t;
  endfunction

  always @(posedge clk) begin
    bit zz, lf, nf;
    if (!rst_n) begin
      for (int i = 0; i < 80; i++) begin ms[i] = 1'b0; mb[i] = 1'b0; end
      mphase = 0; mcnt = 0; mvalid = 1'b0; mbit = 1'b0;
    end else if (load) begin
      for (int i = 0; i < 80; i++) mb[i] = key[i];
      for (int i = 0; i < 80; i++) ms[i] = (i < 64) ? iv[i] : 1'b1;
      mphase = 1; mcnt = 160; mvalid = 1'b0;
    end else begin
      mvalid = 1'b0;
      if (en && mphase != 0) begin
        zz = model_z();
        lf = model_lin();
        nf = model_nl();
        if (mphase == 1) begin
          lf ^= zz; nf ^= zz;
          mcnt--;
          if (mcnt == 0) mphase = 2;
        end else begin
          mbit = zz; mvalid = 1'b1;
        end
        for (int i = 0; i < 79; i++) begin ms[i] = ms[i+1]; mb[i] = mb[i+1]; end
        ms[79] = lf; mb[79] = nf;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk(ks_valid == mvalid, "R3 R7 valid timing", ks_valid, mvalid);
      if (mvalid) chk(ks_bit == mbit, "R4 R5 R6 keystream bit", ks_bit, mbit);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(logic [79:0] k, logic [63:0] v, bit e);
    key = k; iv = v; load = 1'b1; en = e;
    cyc(1);
    load = 1'b0;
  endtask

  initial begin
    int seen;
    bit lf;
    cyc(3);
    chk(ks_valid == 1'b0, "R1 reset valid", ks_valid, 0);
    chk(ks_bit == 1'b0, "R1 reset bit", ks_bit, 0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    en = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin cyc(1); if (ks_valid) seen++; end
    chk(seen == 0, "R1 no valid before load", seen, 0);

    do_load(80'h0123_4567_89AB_CDEF_1357, 64'h0F1E_2D3C_4B5A_6978, 1'b1);
    en = 1'b1;
    seen = 0;
    for (int i = 0; i < 159; i++) begin cyc(1); if (ks_valid) seen++; end
    chk(seen == 0, "R3 quiet during init", seen, 0);
    cyc(1);
    chk(ks_valid == 1'b0, "R3 still quiet at 160th init clock", ks_valid, 0);
    cyc(1);
    chk(ks_valid == 1'b1, "R3 first bit on 161st enabled clock", ks_valid, 1);
    cyc(300);

    lf = 1'b1;
    for (int i = 0; i < 400; i++) begin
      en = lf;
      lf = lf ^ (i % 3 == 0) ^ (i % 7 == 0);
      cyc(1);
    end
    en = 1'b0;
    cyc(1);
    cyc(5);
    chk(ks_valid == 1'b0, "R7 paused valid low", ks_valid, 0);
    en = 1'b1;
    cyc(2);
    chk(ks_valid == 1'b1, "R7 resumes after pause", ks_valid, 1);

    do_load(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0);
    en = 1'b0;
    cyc(10);
    chk(ks_valid == 1'b0, "R2 load with en low, idle", ks_valid, 0);
    seen = 0;
    for (int i = 0; i < 320; i++) begin
      en = (i % 2 == 0);
      cyc(1);
      if (ks_valid) seen++;
    end
    en = 1'b1;
    cyc(50);

    do_load(80'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    en = 1'b1;
    cyc(80);
    do_load(80'hA5A5_5A5A_C3C3_3C3C_9669, 64'hDEAD_BEEF_0BAD_F00D, 1'b1);
    en = 1'b1;
    seen = 0;
    for (int i = 0; i < 160; i++) begin cyc(1); if (ks_valid) seen++; end
    chk(seen == 0, "R2 reload restarts init", seen, 0);
    cyc(1);
    chk(ks_valid == 1'b1, "R2 R3 first bit after reload", ks_valid, 1);
    cyc(200);

    rst_n = 1'b0;
    cyc(1);
    chk(ks_valid == 1'b0, "R1 reset mid-run valid", ks_valid, 0);
    chk(ks_bit == 1'b0, "R1 reset mid-run bit", ks_bit, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 200; i++) begin cyc(1); if (ks_valid) seen++; end
    chk(seen == 0, "R1 no valid after reset without load", seen, 0);

    compare_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule